// File: doc/BRIEF.md
# Parallel Memory Read-Scan Signature Sequencer

This block runs a read-only test of a 16K x 8 parallel memory that has active-low chip-enable, output-enable and program strobes. On a start request it walks the whole address space as four segments of 4096 locations. The first three segments run upward from their base address. The last segment runs downward from the top address. Every byte read is folded into a 16-bit signature register. At the end of each segment, that signature is stored and compared against an expected value supplied by the surrounding logic.

A second mode checks one data line only. It walks the lowest 256 addresses and folds in just the selected bit. Each address is held for a fixed number of clocks, and the byte is taken late in that period. An optional quiet gap, with both enables high, can be placed in front of every segment after the first. The block never programs the memory.

Top module: `eprom_scan_seq`

## Requirements
- R1: A `start` pulse while `busy` is 0 begins a run, and `busy` reads 1 from the next cycle until the run finishes. A `start` pulse while `busy` is 1 has no effect on the run in progress.
- R2: With `mode_pin`=0, segments 0, 1 and 2 begin at 0x0000, 0x1000 and 0x2000 and step up by one. Each segment applies exactly 4096 addresses, and each address lies inside its segment (upper two address bits equal the segment number).
- R3: Segment 3 begins at 0x3FFF and steps down by one to 0x3000, applying 4096 addresses.
- R4: Whenever chip-enable is low, output-enable is low and the program strobe is high. The program strobe is high at all times.
- R5: Each address is held for CYC_LEN clocks with the enables low. The data byte is taken in clock SAMPLE_AT of that period, counting the first clock of the period as 0.
- R6: The signature is CRC-16 with polynomial 0x1021, shifted in MSB first. It is seeded to 0xFFFF at the start of every segment or pin test. A whole byte is shifted in bit 7 first.
- R7: With `mode_pin`=1, addresses 0x0000 to 0x00FF are applied in ascending order and only bit `pin_sel` of the data is folded. The result appears in slot 0 of `sig_out` and is compared with slot 0 of `exp_sig`. Slot k occupies bits 16k+15 to 16k.
- R8: After each segment or pin test, a signature that differs from its expected slot sets `fail`, which stays set until the next accepted start. `fail_idx` holds the segment number, or the pin number in pin mode, of the first mismatch.
- R9: Before segments 1 to 3 both enables stay high for `cool_len`+1 clocks: one check clock plus `cool_len` quiet clocks. Data seen while an enable is high is never folded.
- R10: `done` pulses for one clock as `busy` falls. At that moment `sig_out`, `fail` and `fail_idx` hold the results of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request pulse |
| mode_pin | input | 1 | 0 = full segmented scan, 1 = single data-line test |
| pin_sel | input | 3 | Data line tested in pin mode |
| cool_len | input | 16 | Quiet clocks before segments 1 to 3 |
| exp_sig | input | 64 | Expected signatures, slot k at bits 16k+15:16k |
| mem_addr | output | 14 | Memory address |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| pgm_n | output | 1 | Program strobe, held high |
| mem_data | input | 8 | Memory data bus |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock end-of-run pulse |
| sig_out | output | 64 | Stored signatures, slot k at bits 16k+15:16k |
| fail | output | 1 | Sticky signature mismatch flag |
| fail_idx | output | 3 | Segment or pin of the first mismatch |

## Verification
The memory model in the bench returns the true byte only in the clock that R5 names. In every other clock of the period it returns the inverted byte, and it returns a fixed junk byte while an enable is high. A design that samples one clock early or late, or folds junk during the gap, therefore gives a wrong signature. The bench tracks every address against its own model of the sequence, so it catches each of these faults:
- a descending last segment that starts at 0x3000 or runs upward;
- a segment that is one address short or long;
- a repeated address.

The gap in front of each segment is timed for both a non-zero and a zero `cool_len`. Corrupted expected values check that `fail` latches the first failing index and is cleared by the next run. A start pulse in the middle of a full scan checks that mode and pin are not reloaded.

// File: rtl/eprom_scan_pkg.sv
package eprom_scan_pkg;

  localparam int          SIG_W    = 16;
  localparam logic [15:0] SIG_POLY = 16'h1021;
  localparam logic [15:0] SIG_SEED = 16'hFFFF;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_COOL
  } scan_state_e;

  // One shift of the signature register with a single input bit.
  function automatic logic [SIG_W-1:0] sig_shift(input logic [SIG_W-1:0] s, input logic b);
    logic fb;
    fb = s[SIG_W-1] ^ b;
    return {s[SIG_W-2:0], 1'b0} ^ (fb ? SIG_POLY : '0);
  endfunction

endpackage

// File: rtl/scan_cycle_timer.sv
module scan_cycle_timer #(
  parameter int CYC_LEN   = 60,
  parameter int SAMPLE_AT = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sample_hit,
  output logic period_end
);

  localparam int CW = (CYC_LEN > 2) ? $clog2(CYC_LEN) : 1;

  logic [CW-1:0] cyc;

  assign sample_hit = run && (cyc == CW'(SAMPLE_AT));
  assign period_end = run && (cyc == CW'(CYC_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || period_end) cyc <= '0;
    else                           cyc <= cyc + 1'b1;
  end

  // R5: the phase counter never leaves the period
  assert_cyc_bound_R5: assert property (@(posedge clk) disable iff (rst)
    int'(cyc) < CYC_LEN);

  // R5: a period restarts at phase 0 after its last clock
  assert_cyc_restart_R5: assert property (@(posedge clk) disable iff (rst)
    period_end |=> (cyc == '0));

endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen #(
  parameter int ADDR_W = 14,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_down,
  input  logic              step_en,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  step
);

  logic down_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      step   <= '0;
      down_q <= 1'b0;
    end else if (load) begin
      addr   <= load_addr;
      step   <= '0;
      down_q <= load_down;
    end else if (step_en) begin
      addr <= down_q ? addr - 1'b1 : addr + 1'b1;
      step <= step + 1'b1;
    end
  end

  // R2: a segment is never reloaded in the same clock that it advances
  assert_load_step_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(load && step_en));

  // R3: a load always restarts the step count
  assert_load_clears_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (step == '0));

endmodule

// File: rtl/sig_lfsr.sv
module sig_lfsr
  import eprom_scan_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              fold,
  input  logic              bit_mode,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic [DATA_W-1:0] data,
  output logic [SIG_W-1:0]  sig
);

  logic [SIG_W-1:0] nxt;

  always_comb begin
    nxt = sig;
    if (bit_mode) begin
      nxt = sig_shift(sig, data[bit_sel]);
    end else begin
      for (int i = DATA_W - 1; i >= 0; i--) nxt = sig_shift(nxt, data[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init) sig <= SIG_SEED;
    else if (fold)   sig <= nxt;
  end

  // R6: seeding and folding never coincide
  assert_init_fold_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(init && fold));

  // R6: the signature starts from the seed after every init
  assert_seed_R6: assert property (@(posedge clk) disable iff (rst)
    init |=> (sig == SIG_SEED));

endmodule

// File: rtl/eprom_scan_seq.sv
module eprom_scan_seq
  import eprom_scan_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int NUM_SEG   = 4,
  parameter int PIN_LEN   = 256,
  parameter int CYC_LEN   = 60,
  parameter int SAMPLE_AT = 50,
  parameter int COOL_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        mode_pin,
  input  logic [$clog2(DATA_W)-1:0]   pin_sel,
  input  logic [COOL_W-1:0]           cool_len,
  input  logic [NUM_SEG*SIG_W-1:0]    exp_sig,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic                        ce_n,
  output logic                        oe_n,
  output logic                        pgm_n,
  input  logic [DATA_W-1:0]           mem_data,
  output logic                        busy,
  output logic                        done,
  output logic [NUM_SEG*SIG_W-1:0]    sig_out,
  output logic                        fail,
  output logic [((NUM_SEG > 1 ? $clog2(NUM_SEG) : 1) > $clog2(DATA_W) ?
                 (NUM_SEG > 1 ? $clog2(NUM_SEG) : 1) : $clog2(DATA_W))-1:0] fail_idx
);

  localparam int SEG_LEN = (1 << ADDR_W) / NUM_SEG;
  localparam int SEG_W   = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;
  localparam int PIN_W   = $clog2(DATA_W);
  localparam int IDX_W   = (SEG_W > PIN_W) ? SEG_W : PIN_W;
  localparam int RUN_MAX = (SEG_LEN > PIN_LEN) ? SEG_LEN : PIN_LEN;
  localparam int CNT_W   = $clog2(RUN_MAX);

  scan_state_e state, state_nxt;

  logic [SEG_W-1:0]  seg_q;
  logic              mode_q;
  logic [PIN_W-1:0]  pin_q;
  logic [COOL_W-1:0] cool_cnt;
  logic              ce_q, oe_q, pgm_q, busy_q, done_q, fail_q;
  logic [IDX_W-1:0]  fail_idx_q;

  logic              sample_hit, period_end;
  logic [CNT_W-1:0]  step;
  logic              last_step, final_seg, start_ok;
  logic              ld, ld_down, step_en, fold;
  logic [ADDR_W-1:0] ld_addr;
  logic [SEG_W-1:0]  next_seg, slot;
  logic [SIG_W-1:0]  sig_cur;
  logic              mismatch;
  logic [IDX_W-1:0]  cur_idx;

  logic [NUM_SEG-1:0][SIG_W-1:0] exp_arr;
  logic [NUM_SEG-1:0][SIG_W-1:0] sig_arr;

  assign exp_arr = exp_sig;
  assign sig_out = sig_arr;

  function automatic logic [ADDR_W-1:0] seg_base(input logic [SEG_W-1:0] s);
    if (int'(s) == NUM_SEG - 1) return '1;
    return ADDR_W'(int'(s) * SEG_LEN);
  endfunction

  // ---------------- control decode ----------------
  assign start_ok  = (state == ST_IDLE) && start;
  assign last_step = mode_q ? (step == CNT_W'(PIN_LEN - 1)) : (step == CNT_W'(SEG_LEN - 1));
  assign final_seg = mode_q || (int'(seg_q) == NUM_SEG - 1);
  assign slot      = mode_q ? '0 : seg_q;
  assign cur_idx   = mode_q ? IDX_W'(pin_q) : IDX_W'(seg_q);
  assign mismatch  = (sig_cur != exp_arr[slot]);

  assign next_seg = (state == ST_IDLE) ? '0 : seg_q + 1'b1;
  assign ld       = start_ok || ((state == ST_CHECK) && !final_seg);
  assign ld_addr  = (start_ok && mode_pin) ? '0 : seg_base(next_seg);
  assign ld_down  = !(start_ok && mode_pin) && (int'(next_seg) == NUM_SEG - 1);
  assign step_en  = period_end && !last_step;
  assign fold     = sample_hit && !ce_q && !oe_q;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:  if (start) state_nxt = ST_READ;
      ST_READ:  if (period_end && last_step) state_nxt = ST_CHECK;
      ST_CHECK: begin
        if (final_seg)          state_nxt = ST_IDLE;
        else if (cool_len != 0) state_nxt = ST_COOL;
        else                    state_nxt = ST_READ;
      end
      ST_COOL:  if (cool_cnt == cool_len - 1'b1) state_nxt = ST_READ;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  // ---------------- sub-blocks ----------------
  scan_cycle_timer #(.CYC_LEN(CYC_LEN), .SAMPLE_AT(SAMPLE_AT)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .run        (state == ST_READ),
    .sample_hit (sample_hit),
    .period_end (period_end)
  );

  scan_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (ld),
    .load_addr (ld_addr),
    .load_down (ld_down),
    .step_en   (step_en),
    .addr      (mem_addr),
    .step      (step)
  );

  sig_lfsr #(.DATA_W(DATA_W), .SEL_W(PIN_W)) u_sig (
    .clk      (clk),
    .rst      (rst),
    .init     (ld),
    .fold     (fold),
    .bit_mode (mode_q),
    .bit_sel  (pin_q),
    .data     (mem_data),
    .sig      (sig_cur)
  );

  // ---------------- sequencing registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      seg_q      <= '0;
      mode_q     <= 1'b0;
      pin_q      <= '0;
      cool_cnt   <= '0;
      ce_q       <= 1'b1;
      oe_q       <= 1'b1;
      pgm_q      <= 1'b1;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
      fail_idx_q <= '0;
    end else begin
      state    <= state_nxt;
      busy_q   <= (state_nxt != ST_IDLE);
      ce_q     <= (state_nxt != ST_READ);
      oe_q     <= (state_nxt != ST_READ);
      pgm_q    <= 1'b1;
      done_q   <= 1'b0;
      cool_cnt <= (state == ST_COOL) ? cool_cnt + 1'b1 : '0;
      if (start_ok) begin
        mode_q     <= mode_pin;
        pin_q      <= pin_sel;
        seg_q      <= '0;
        fail_q     <= 1'b0;
        fail_idx_q <= '0;
      end
      if (state == ST_CHECK) begin
        if (mismatch && !fail_q) begin
          fail_q     <= 1'b1;
          fail_idx_q <= cur_idx;
        end
        if (final_seg) done_q <= 1'b1;
        else           seg_q  <= seg_q + 1'b1;
      end
    end
  end

  // Result slots, one register bank per segment.
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                       sig_arr[g] <= '0;
      else if ((state == ST_CHECK) && (int'(slot) == g)) sig_arr[g] <= sig_cur;
    end
  end

  assign ce_n     = ce_q;
  assign oe_n     = oe_q;
  assign pgm_n    = pgm_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign fail     = fail_q;
  assign fail_idx = fail_idx_q;

  // ---------------- assertions ----------------
  // R4: a read strobe pattern never has program active or output disabled
  assert_read_strobes_R4: assert property (@(posedge clk) disable iff (rst)
    !ce_n |-> (!oe_n && pgm_n));

  // R2: in full-scan mode the address stays in the current segment
  assert_seg_window_R2: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !mode_q) |-> (mem_addr[ADDR_W-1 -: SEG_W] == seg_q));

  // R7: pin tests stay in the low address window
  assert_pin_window_R7: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && mode_q) |-> (int'(mem_addr) < PIN_LEN));

  // R9: the quiet gap keeps both enables high
  assert_cool_dark_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COOL) |-> (ce_n && oe_n));

  // R8: fail is only cleared by an accepted start
  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (fail && !(start && !busy)) |=> fail);

  // R10: done coincides with busy falling
  assert_done_edge_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));

  // R1: busy rises the clock after an accepted start
  assert_busy_rise_R1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

endmodule

// File: tb/eprom_scan_seq_tb.sv
module eprom_scan_seq_tb;

  localparam int CYC  = 4;
  localparam int SAMP = 2;
  localparam int NSEG = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mode_pin = 1'b0;
  logic [2:0]  pin_sel = '0;
  logic [15:0] cool_len = '0;
  logic [63:0] exp_sig = '0;
  logic [13:0] mem_addr;
  logic        ce_n, oe_n, pgm_n;
  logic [7:0]  mem_data;
  logic        busy, done, fail;
  logic [63:0] sig_out;
  logic [2:0]  fail_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  eprom_scan_seq #(.CYC_LEN(CYC), .SAMPLE_AT(SAMP)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode_pin(mode_pin), .pin_sel(pin_sel),
    .cool_len(cool_len), .exp_sig(exp_sig), .mem_addr(mem_addr), .ce_n(ce_n),
    .oe_n(oe_n), .pgm_n(pgm_n), .mem_data(mem_data), .busy(busy), .done(done),
    .sig_out(sig_out), .fail(fail), .fail_idx(fail_idx)
  );

  // ---------------- memory model ----------------
  function automatic logic [7:0] rom(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h3C;
  endfunction

  int ph = 0;
  always @(posedge clk) begin
    if (ce_n || oe_n) ph <= 0;
    else              ph <= (ph == CYC - 1) ? 0 : ph + 1;
  end

  // True byte only in the sample clock; inverted otherwise; junk when disabled.
  assign mem_data = (!ce_n && !oe_n) ? ((ph == SAMP) ? rom(mem_addr) : ~rom(mem_addr)) : 8'hC3;

  // ---------------- reference model ----------------
  function automatic logic [15:0] shf(input logic [15:0] s, input logic b);
    logic fb;
    fb = s[15] ^ b;
    return {s[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  function automatic logic [13:0] exp_addr(input logic pm, input int n);
    int s, o;
    if (pm) return 14'(n);
    s = n / 4096;
    o = n % 4096;
    if (s < 3) return 14'(s * 4096 + o);
    return 14'(16383 - o);
  endfunction

  function automatic logic [15:0] ref_seg(input int s);
    logic [15:0] c;
    logic [7:0]  d;
    c = 16'hFFFF;
    for (int n = 0; n < 4096; n++) begin
      d = rom(exp_addr(1'b0, s * 4096 + n));
      for (int i = 7; i >= 0; i--) c = shf(c, d[i]);
    end
    return c;
  endfunction

  function automatic logic [15:0] ref_pin(input int p);
    logic [15:0] c;
    logic [7:0]  d;
    c = 16'hFFFF;
    for (int n = 0; n < 256; n++) begin
      d = rom(14'(n));
      c = shf(c, d[p]);
    end
    return c;
  endfunction

  // ---------------- sequence monitor ----------------
  logic mon_clr = 1'b1;
  logic mon_mode = 1'b0;
  int   mon_cool = 0;
  int   mon_n, mon_addr_err, mon_hold_err, mon_gap_err, mon_strobe_err;
  int   hold, gap;
  logic was_low;
  logic [13:0] last_addr;

  always @(negedge clk) begin
    if (mon_clr) begin
      mon_n = 0; mon_addr_err = 0; mon_hold_err = 0; mon_gap_err = 0; mon_strobe_err = 0;
      hold = 0; gap = 0; was_low = 1'b0; last_addr = '0;
    end else begin
      if (!pgm_n) mon_strobe_err++;
      if (!ce_n) begin
        if (oe_n) mon_strobe_err++;
        if (!was_low || mem_addr != last_addr) begin
          if (was_low && hold != CYC) mon_hold_err++;
          if (mem_addr != exp_addr(mon_mode, mon_n)) mon_addr_err++;
          if (!was_low && mon_n != 0 && gap != mon_cool + 1) mon_gap_err++;
          mon_n++;
          hold = 1;
          last_addr = mem_addr;
        end else begin
          hold++;
        end
        gap = 0;
        was_low = 1'b1;
      end else begin
        if (was_low && hold != CYC) mon_hold_err++;
        if (busy) gap++;
        was_low = 1'b0;
      end
    end
  end

  // ---------------- check helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Starts a run and waits for its done pulse (sampled at a negedge).
  task automatic do_run(input logic pm, input logic [2:0] p, input int cool,
                        input logic [63:0] ev, input bit poke);
    @(negedge clk);
    mode_pin = pm; pin_sel = p; cool_len = 16'(cool); exp_sig = ev;
    mon_mode = pm; mon_cool = cool; mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", 64'(busy), 64'd1);
    if (poke) begin
      repeat (500) @(negedge clk);
      mode_pin = 1'b1; pin_sel = 3'd3; start = 1'b1;   // R1: must be ignored
      @(negedge clk);
      start = 1'b0; mode_pin = pm; pin_sel = p;
    end
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R10", "busy low with done", 64'(busy), 64'd0);
    chk(mon_strobe_err == 0, "R4", "strobe violations", 64'(mon_strobe_err), 64'd0);
    chk(mon_hold_err == 0, "R5", "address hold errors", 64'(mon_hold_err), 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done is one clock", 64'(done), 64'd0);
  endtask

  // ---------------- stimulus table: {pin, corrupt} ----------------
  localparam logic [3:0] PIN_TAB [8] = '{
    {3'd0, 1'b0}, {3'd5, 1'b0}, {3'd7, 1'b1}, {3'd2, 1'b0},
    {3'd1, 1'b0}, {3'd6, 1'b0}, {3'd3, 1'b1}, {3'd4, 1'b0}
  };

  logic [15:0] seg_ref [NSEG];

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    chk(busy == 1'b0, "R1", "reset busy", 64'(busy), 64'd0);
    chk(done == 1'b0, "R10", "reset done", 64'(done), 64'd0);
    chk(ce_n && oe_n, "R4", "reset enables", {62'd0, ce_n, oe_n}, 64'd3);
    chk(pgm_n == 1'b1, "R4", "reset program strobe", 64'(pgm_n), 64'd1);
    chk(fail == 1'b0, "R8", "reset fail", 64'(fail), 64'd0);

    // Table walk: single data-line tests (R7, R6, R5, R8)
    for (int k = 0; k < 8; k++) begin
      logic [2:0]  p;
      logic        bad;
      logic [15:0] r;
      p   = PIN_TAB[k][3:1];
      bad = PIN_TAB[k][0];
      r   = ref_pin(int'(p));
      do_run(1'b1, p, 0, {48'd0, r ^ {15'd0, bad}}, 1'b0);
      chk(sig_out[15:0] == r, "R7", "pin signature", 64'(sig_out[15:0]), 64'(r));
      chk(mon_n == 256, "R7", "pin address count", 64'(mon_n), 64'd256);
      chk(mon_addr_err == 0, "R7", "pin address order", 64'(mon_addr_err), 64'd0);
      chk(fail == bad, "R8", "pin fail flag", 64'(fail), 64'(bad));
      if (bad) chk(fail_idx == p, "R8", "pin fail index", 64'(fail_idx), 64'(p));
    end

    for (int s = 0; s < NSEG; s++) seg_ref[s] = ref_seg(s);

    // Full scan with a quiet gap, a bad expected value on segment 2 and a start poke
    begin
      logic [63:0] ev;
      ev = {seg_ref[3], seg_ref[2] ^ 16'h0100, seg_ref[1], seg_ref[0]};
      do_run(1'b0, 3'd0, 3, ev, 1'b1);
      for (int s = 0; s < NSEG; s++)
        chk(sig_out[16*s +: 16] == seg_ref[s], "R6", "segment signature",
            64'(sig_out[16*s +: 16]), 64'(seg_ref[s]));
      chk(mon_n == 16384, "R2", "full scan address count", 64'(mon_n), 64'd16384);
      chk(mon_addr_err == 0, "R3", "segment order and direction", 64'(mon_addr_err), 64'd0);
      chk(mon_gap_err == 0, "R9", "quiet gap length 3", 64'(mon_gap_err), 64'd0);
      chk(fail == 1'b1, "R8", "segment fail flag", 64'(fail), 64'd1);
      chk(fail_idx == 3'd2, "R8", "segment fail index", 64'(fail_idx), 64'd2);
    end

    // Full scan with no gap and all expected values right: fail cleared by start
    begin
      logic [63:0] ev;
      ev = {seg_ref[3], seg_ref[2], seg_ref[1], seg_ref[0]};
      do_run(1'b0, 3'd0, 0, ev, 1'b0);
      chk(mon_gap_err == 0, "R9", "quiet gap length 0", 64'(mon_gap_err), 64'd0);
      chk(mon_addr_err == 0, "R2", "second scan order", 64'(mon_addr_err), 64'd0);
      chk(fail == 1'b0, "R8", "fail cleared by new run", 64'(fail), 64'd0);
      chk(sig_out[63:48] == seg_ref[3], "R3", "descending segment signature",
          64'(sig_out[63:48]), 64'(seg_ref[3]));
    end

    finish_run();
  end

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog: actual running expected finished");
    finish_run();
  end

endmodule